// File: doc/BRIEF.md
# ATA Taskfile Register Window

This block places the eight registers of an ATA taskfile on a 32-bit memory-mapped request/response port, one register per 32-bit word offset. Host accesses are routed to a drive-side state interface. Writes to the parameter registers and the command register go through only while the drive allows register writes. The block owns the drive interrupt flag and clears it on status-register traffic. Accesses to the data offset pass one 16-bit PIO word across a valid/ready handshake with the drive. Word offsets outside the taskfile hold plain 32-bit scratch words.

The host side uses valid/ready in both directions. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while nothing is in flight, so at most one access is outstanding. Every request, read or write, gets exactly one response beat. A response stays on `rsp_valid`/`rsp_rdata`, unchanged, until the host raises `rsp_ready`; the host can therefore stall the block for as long as it wants. The PIO data channels follow the same rule in the other direction. A write word stays offered, unchanged, until the drive accepts it. A read waits for as long as the drive withholds data.

Word offset map: 0 data, 1 feature (write) / error (read), 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device, 7 command (write) / status (read), 8 device control (write) / alternate status (read). All other offsets are scratch.

Top module: `ata_taskfile_window`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `irq` is 0, the strobes are 0 and all six taskfile register outputs are 0.
- R2: While `drv_busy` and `drv_drq` are both 0, a write to offset 1, 2, 3, 4, 5 or 6 stores bits [7:0] of the write data into that register. A read of offset 2, 4, 5 or 6 returns the stored byte, zero-extended to 32 bits.
- R3: While `drv_busy` or `drv_drq` is 1, writes to offsets 1 to 7 change no taskfile register. A write to offset 7 then raises no command strobe and leaves `irq` as it was.
- R4: A write to offset 7 while the drive is writable clears `irq`. It also raises `cmd_strobe` for one cycle, in the cycle after acceptance, with `cmd_byte` equal to write data bits [7:0].
- R5: A read of offset 7 returns `drv_status` zero-extended and clears `irq`.
- R6: A read of offset 8 returns `drv_status` and leaves `irq` unchanged. A write to offset 8 raises `ctl_strobe` for one cycle with `ctl_byte` equal to bits [7:0], whatever the value of busy or drq.
- R7: A read of offset 1 returns `drv_error`, and a read of offset 3 returns `drv_aux`, not the stored LBA low byte.
- R8: A write to offset 0 offers write data bits [15:0] on `pio_wr_data` with `pio_wr_valid` held, unchanged, until `pio_wr_ready`. The response comes only after that transfer.
- R9: A read of offset 0 raises `pio_rd_ready` and waits for `pio_rd_valid`. It responds with `pio_rd_data` zero-extended.
- R10: A write to any other offset stores all 32 bits, and a later read of that offset returns them. Each such offset has its own word.
- R11: `req_ready` and `rsp_valid` are never both high. A response held without `rsp_ready` keeps its data unchanged.
- R12: A pulse on `drv_irq_set` sets `irq` on the next edge. If it coincides with a clearing access, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | WORD_W | Word offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| drv_busy | input | 1 | Drive busy flag |
| drv_drq | input | 1 | Drive data-request flag |
| drv_status | input | 8 | Drive status byte |
| drv_error | input | 8 | Drive error byte |
| drv_aux | input | 8 | Drive byte returned at LBA low on read |
| drv_irq_set | input | 1 | Drive raises its interrupt |
| irq | output | 1 | Interrupt flag towards the host |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count register |
| tf_lba0 | output | 8 | LBA low register |
| tf_lba1 | output | 8 | LBA mid register |
| tf_lba2 | output | 8 | LBA high register |
| tf_device | output | 8 | Device register |
| cmd_strobe | output | 1 | One-cycle command issue |
| cmd_byte | output | 8 | Command code |
| ctl_strobe | output | 1 | One-cycle device-control write |
| ctl_byte | output | 8 | Device-control value |
| pio_wr_valid | output | 1 | PIO write word offered |
| pio_wr_ready | input | 1 | Drive takes PIO write word |
| pio_wr_data | output | 16 | PIO write word |
| pio_rd_valid | input | 1 | Drive offers PIO read word |
| pio_rd_ready | output | 1 | Block takes PIO read word |
| pio_rd_data | input | 16 | PIO read word |

## Verification
The bench builds the block with its defaults: a 4-bit word offset, 32-bit host data and a 16-bit PIO word. That leaves seven scratch words, offsets 9 to 15, and the bench writes and reads back the lowest and the highest of them. The 16-bit PIO width lets the bench check that the upper half of a data write is dropped and that a read is zero-extended. It holds back `pio_wr_ready`, `pio_rd_valid` and `rsp_ready` for several cycles to exercise every stall point.

// File: rtl/tfw_pkg.sv
package tfw_pkg;

  typedef enum logic [3:0] {
    K_DATA, K_FEAT, K_COUNT, K_LBA0, K_LBA1, K_LBA2, K_DEV, K_CMD, K_ALT, K_SCR
  } tfw_kind_e;

  typedef enum logic [1:0] {
    S_IDLE, S_PIO_WR, S_PIO_RD, S_RESP
  } tfw_state_e;

  // Number of word offsets taken by the taskfile itself.
  localparam int unsigned TF_WORDS = 9;

  function automatic tfw_kind_e tfw_decode(input int unsigned w);
    case (w)
      0: tfw_decode = K_DATA;
      1: tfw_decode = K_FEAT;
      2: tfw_decode = K_COUNT;
      3: tfw_decode = K_LBA0;
      4: tfw_decode = K_LBA1;
      5: tfw_decode = K_LBA2;
      6: tfw_decode = K_DEV;
      7: tfw_decode = K_CMD;
      8: tfw_decode = K_ALT;
      default: tfw_decode = K_SCR;
    endcase
  endfunction

endpackage

// File: rtl/tfw_regs.sv
module tfw_regs
  import tfw_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_status,
  input  tfw_kind_e        kind,
  input  logic [REG_W-1:0] wbyte,
  input  logic             writable,
  input  logic             irq_set,
  output logic [REG_W-1:0] feature,
  output logic [REG_W-1:0] count,
  output logic [REG_W-1:0] lba0,
  output logic [REG_W-1:0] lba1,
  output logic [REG_W-1:0] lba2,
  output logic [REG_W-1:0] device,
  output logic             cmd_strobe,
  output logic [REG_W-1:0] cmd_byte,
  output logic             ctl_strobe,
  output logic [REG_W-1:0] ctl_byte,
  output logic             irq
);

  logic cmd_go;
  logic irq_clr;

  assign cmd_go  = wr_en && (kind == K_CMD) && writable;
  assign irq_clr = rd_status || cmd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feature    <= '0;
      count      <= '0;
      lba0       <= '0;
      lba1       <= '0;
      lba2       <= '0;
      device     <= '0;
      cmd_strobe <= 1'b0;
      cmd_byte   <= '0;
      ctl_strobe <= 1'b0;
      ctl_byte   <= '0;
    end else begin
      cmd_strobe <= cmd_go;
      ctl_strobe <= 1'b0;
      if (cmd_go) cmd_byte <= wbyte;
      if (wr_en) begin
        case (kind)
          K_FEAT:  if (writable) feature <= wbyte;
          K_COUNT: if (writable) count   <= wbyte;
          K_LBA0:  if (writable) lba0    <= wbyte;
          K_LBA1:  if (writable) lba1    <= wbyte;
          K_LBA2:  if (writable) lba2    <= wbyte;
          K_DEV:   if (writable) device  <= wbyte;
          K_ALT: begin
            ctl_strobe <= 1'b1;
            ctl_byte   <= wbyte;
          end
          default: ;
        endcase
      end
    end
  end

  // A drive event in the same cycle as a clearing access wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

endmodule

// File: rtl/tfw_scratch.sv
module tfw_scratch #(
  parameter int unsigned WORD_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FIRST  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned N = 1 << WORD_W;

  logic [DATA_W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_word
    if (g >= FIRST) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 mem[g] <= '0;
        else if (wr_en && (word == WORD_W'(g)))     mem[g] <= wdata;
      end
    end else begin : g_tied
      assign mem[g] = '0;
    end
  end

  assign rdata = mem[word];

endmodule

// File: rtl/tfw_readmux.sv
module tfw_readmux
  import tfw_pkg::*;
#(
  parameter int unsigned REG_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  tfw_kind_e         kind,
  input  logic [REG_W-1:0]  count,
  input  logic [REG_W-1:0]  lba1,
  input  logic [REG_W-1:0]  lba2,
  input  logic [REG_W-1:0]  device,
  input  logic [REG_W-1:0]  status,
  input  logic [REG_W-1:0]  error,
  input  logic [REG_W-1:0]  aux,
  input  logic [DATA_W-1:0] scratch,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    case (kind)
      K_FEAT:        rdata = DATA_W'(error);
      K_COUNT:       rdata = DATA_W'(count);
      K_LBA0:        rdata = DATA_W'(aux);
      K_LBA1:        rdata = DATA_W'(lba1);
      K_LBA2:        rdata = DATA_W'(lba2);
      K_DEV:         rdata = DATA_W'(device);
      K_CMD, K_ALT:  rdata = DATA_W'(status);
      K_SCR:         rdata = scratch;
      default:       rdata = '0;
    endcase
  end

endmodule

// File: rtl/ata_taskfile_window.sv
module ata_taskfile_window
  import tfw_pkg::*;
#(
  parameter int unsigned WORD_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIO_W  = 16,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              drv_busy,
  input  logic              drv_drq,
  input  logic [REG_W-1:0]  drv_status,
  input  logic [REG_W-1:0]  drv_error,
  input  logic [REG_W-1:0]  drv_aux,
  input  logic              drv_irq_set,
  output logic              irq,
  output logic [REG_W-1:0]  tf_feature,
  output logic [REG_W-1:0]  tf_count,
  output logic [REG_W-1:0]  tf_lba0,
  output logic [REG_W-1:0]  tf_lba1,
  output logic [REG_W-1:0]  tf_lba2,
  output logic [REG_W-1:0]  tf_device,
  output logic              cmd_strobe,
  output logic [REG_W-1:0]  cmd_byte,
  output logic              ctl_strobe,
  output logic [REG_W-1:0]  ctl_byte,
  output logic              pio_wr_valid,
  input  logic              pio_wr_ready,
  output logic [PIO_W-1:0]  pio_wr_data,
  input  logic              pio_rd_valid,
  output logic              pio_rd_ready,
  input  logic [PIO_W-1:0]  pio_rd_data
);

  tfw_state_e        state;
  tfw_kind_e         kind;
  logic              accept;
  logic              reg_wr;
  logic              rd_status;
  logic              writable;
  logic [DATA_W-1:0] mux_rdata;
  logic [DATA_W-1:0] scr_rdata;

  assign kind      = tfw_decode(int'(req_word));
  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign reg_wr    = accept && req_write && (kind != K_DATA);
  assign rd_status = accept && !req_write && (kind == K_CMD);
  assign writable  = !drv_busy && !drv_drq;

  assign rsp_valid    = (state == S_RESP);
  assign pio_wr_valid = (state == S_PIO_WR);
  assign pio_rd_ready = (state == S_PIO_RD);

  tfw_regs #(.REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .rd_status  (rd_status),
    .kind       (kind),
    .wbyte      (req_wdata[REG_W-1:0]),
    .writable   (writable),
    .irq_set    (drv_irq_set),
    .feature    (tf_feature),
    .count      (tf_count),
    .lba0       (tf_lba0),
    .lba1       (tf_lba1),
    .lba2       (tf_lba2),
    .device     (tf_device),
    .cmd_strobe (cmd_strobe),
    .cmd_byte   (cmd_byte),
    .ctl_strobe (ctl_strobe),
    .ctl_byte   (ctl_byte),
    .irq        (irq)
  );

  tfw_scratch #(.WORD_W(WORD_W), .DATA_W(DATA_W), .FIRST(TF_WORDS)) u_scratch (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr && (kind == K_SCR)),
    .word  (req_word),
    .wdata (req_wdata),
    .rdata (scr_rdata)
  );

  tfw_readmux #(.REG_W(REG_W), .DATA_W(DATA_W)) u_mux (
    .kind    (kind),
    .count   (tf_count),
    .lba1    (tf_lba1),
    .lba2    (tf_lba2),
    .device  (tf_device),
    .status  (drv_status),
    .error   (drv_error),
    .aux     (drv_aux),
    .scratch (scr_rdata),
    .rdata   (mux_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      rsp_rdata   <= '0;
      pio_wr_data <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          if (kind == K_DATA) begin
            if (req_write) begin
              pio_wr_data <= req_wdata[PIO_W-1:0];
              state       <= S_PIO_WR;
            end else begin
              state <= S_PIO_RD;
            end
          end else begin
            rsp_rdata <= req_write ? '0 : mux_rdata;
            state     <= S_RESP;
          end
        end
        S_PIO_WR: if (pio_wr_ready) begin
          rsp_rdata <= '0;
          state     <= S_RESP;
        end
        S_PIO_RD: if (pio_rd_valid) begin
          rsp_rdata <= DATA_W'(pio_rd_data);
          state     <= S_RESP;
        end
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tfw_checker.sv
module tfw_checker #(
  parameter int unsigned WORD_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PIO_W  = 16,
  parameter int unsigned REG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [WORD_W-1:0] req_word,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              drv_busy,
  input logic              drv_drq,
  input logic              drv_irq_set,
  input logic              irq,
  input logic [REG_W-1:0]  tf_feature,
  input logic [REG_W-1:0]  tf_count,
  input logic [REG_W-1:0]  tf_lba0,
  input logic [REG_W-1:0]  tf_lba1,
  input logic [REG_W-1:0]  tf_lba2,
  input logic [REG_W-1:0]  tf_device,
  input logic              cmd_strobe,
  input logic              pio_wr_valid,
  input logic              pio_wr_ready,
  input logic [PIO_W-1:0]  pio_wr_data
);

  logic acc;
  logic blocked;
  assign acc     = req_valid && req_ready;
  assign blocked = drv_busy || drv_drq;

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r8_pio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pio_wr_valid && !pio_wr_ready |=> pio_wr_valid && $stable(pio_wr_data));

  a_r3_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_write && (req_word >= WORD_W'(1)) && (req_word <= WORD_W'(6)) && blocked
    |=> $stable({tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device}));

  a_r4_cmd_source: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> $past(acc && req_write && (req_word == WORD_W'(7)) && !blocked));

  a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(acc && (req_word == WORD_W'(7))));

  a_r12_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    drv_irq_set |=> irq);

  a_r6_alt_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && (req_word == WORD_W'(8)) && irq |=> irq);

endmodule

bind ata_taskfile_window tfw_checker #(
  .WORD_W(WORD_W), .DATA_W(DATA_W), .PIO_W(PIO_W), .REG_W(REG_W)
) u_tfw_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_word     (req_word),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .drv_busy     (drv_busy),
  .drv_drq      (drv_drq),
  .drv_irq_set  (drv_irq_set),
  .irq          (irq),
  .tf_feature   (tf_feature),
  .tf_count     (tf_count),
  .tf_lba0      (tf_lba0),
  .tf_lba1      (tf_lba1),
  .tf_lba2      (tf_lba2),
  .tf_device    (tf_device),
  .cmd_strobe   (cmd_strobe),
  .pio_wr_valid (pio_wr_valid),
  .pio_wr_ready (pio_wr_ready),
  .pio_wr_data  (pio_wr_data)
);

// File: tb/ata_taskfile_window_test.sv
module ata_taskfile_window_test;

  localparam int WORD_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [WORD_W-1:0] req_word = '0;
  logic [31:0]       req_wdata = '0;
  logic              drv_busy = 0, drv_drq = 0, drv_irq_set = 0;
  logic [7:0]        drv_status = 8'h58, drv_error = 8'h04, drv_aux = 8'h9C;
  logic              pio_wr_ready = 1, pio_rd_valid = 0;
  logic [15:0]       pio_rd_data = '0;
  logic              req_ready, rsp_valid, irq, cmd_strobe, ctl_strobe;
  logic              pio_wr_valid, pio_rd_ready;
  logic [31:0]       rsp_rdata;
  logic [7:0]        tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device;
  logic [7:0]        cmd_byte, ctl_byte;
  logic [15:0]       pio_wr_data;

  ata_taskfile_window uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_word(req_word), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .drv_busy(drv_busy), .drv_drq(drv_drq), .drv_status(drv_status),
    .drv_error(drv_error), .drv_aux(drv_aux), .drv_irq_set(drv_irq_set),
    .irq(irq),
    .tf_feature(tf_feature), .tf_count(tf_count), .tf_lba0(tf_lba0),
    .tf_lba1(tf_lba1), .tf_lba2(tf_lba2), .tf_device(tf_device),
    .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte),
    .ctl_strobe(ctl_strobe), .ctl_byte(ctl_byte),
    .pio_wr_valid(pio_wr_valid), .pio_wr_ready(pio_wr_ready), .pio_wr_data(pio_wr_data),
    .pio_rd_valid(pio_rd_valid), .pio_rd_ready(pio_rd_ready), .pio_rd_data(pio_rd_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Values seen at the falling edge right after the acceptance edge.
  logic       s_cmd, s_ctl, s_irq;
  logic [7:0] s_cmd_byte, s_ctl_byte;

  task automatic issue(input logic wr, input logic [WORD_W-1:0] w, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = w; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    s_cmd = cmd_strobe; s_cmd_byte = cmd_byte;
    s_ctl = ctl_strobe; s_ctl_byte = ctl_byte; s_irq = irq;
  endtask

  task automatic wait_rsp(output logic [31:0] d);
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic access(input logic wr, input logic [WORD_W-1:0] w,
                        input logic [31:0] d, output logic [31:0] r);
    issue(wr, w, d);
    wait_rsp(r);
  endtask

  task automatic pulse_irq();
    @(negedge clk); drv_irq_set = 1;
    @(negedge clk); drv_irq_set = 0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [3:0]  word;
    logic [31:0] wdata;
    logic        busy;
    logic        drq;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd2, 32'hABCD1234, 1'b0, 1'b0, 32'h0,        8'd2},  // R2 count
    '{1'b0, 4'd2, 32'h0,        1'b0, 1'b0, 32'h34,       8'd2},  // R2
    '{1'b1, 4'd4, 32'h000000A5, 1'b0, 1'b0, 32'h0,        8'd2},  // R2 lba mid
    '{1'b0, 4'd4, 32'h0,        1'b0, 1'b0, 32'hA5,       8'd2},  // R2
    '{1'b1, 4'd5, 32'hFFFFFF5A, 1'b0, 1'b0, 32'h0,        8'd2},  // R2 lba high
    '{1'b0, 4'd5, 32'h0,        1'b0, 1'b0, 32'h5A,       8'd2},  // R2
    '{1'b1, 4'd6, 32'h000000E0, 1'b0, 1'b0, 32'h0,        8'd2},  // R2 device
    '{1'b0, 4'd6, 32'h0,        1'b0, 1'b0, 32'hE0,       8'd2},  // R2
    '{1'b1, 4'd2, 32'h00000077, 1'b1, 1'b0, 32'h0,        8'd3},  // R3 busy
    '{1'b0, 4'd2, 32'h0,        1'b0, 1'b0, 32'h34,       8'd3},  // R3
    '{1'b1, 4'd6, 32'h00000011, 1'b0, 1'b1, 32'h0,        8'd3},  // R3 drq
    '{1'b0, 4'd6, 32'h0,        1'b0, 1'b0, 32'hE0,       8'd3},  // R3
    '{1'b0, 4'd1, 32'h0,        1'b0, 1'b0, 32'h04,       8'd7},  // R7 error
    '{1'b1, 4'd3, 32'h00000066, 1'b0, 1'b0, 32'h0,        8'd7},  // R7
    '{1'b0, 4'd3, 32'h0,        1'b0, 1'b0, 32'h9C,       8'd7},  // R7 aux
    '{1'b0, 4'd7, 32'h0,        1'b0, 1'b0, 32'h58,       8'd5},  // R5 status
    '{1'b0, 4'd8, 32'h0,        1'b0, 1'b0, 32'h58,       8'd6},  // R6 alt
    '{1'b1, 4'd9, 32'hDEADBEEF, 1'b0, 1'b0, 32'h0,        8'd10}, // R10 low
    '{1'b1, 4'd15,32'h12345678, 1'b0, 1'b0, 32'h0,        8'd10}, // R10 high
    '{1'b0, 4'd9, 32'h0,        1'b0, 1'b0, 32'hDEADBEEF, 8'd10}, // R10
    '{1'b0, 4'd15,32'h0,        1'b0, 1'b0, 32'h12345678, 8'd10}  // R10
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 strobes", {30'd0, cmd_strobe, ctl_strobe}, 32'd0);
    check("R1 taskfile", {tf_feature, tf_count, tf_lba0, tf_lba1} | {8'd0, tf_lba2, tf_device, 8'd0}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drv_busy = VECS[i].busy;
      drv_drq  = VECS[i].drq;
      access(VECS[i].wr, VECS[i].word, VECS[i].wdata, r);
      drv_busy = 0; drv_drq = 0;
      if (!VECS[i].wr) check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].exp);
    end
    check("R2 lba low stored", 32'(tf_lba0), 32'h66);
    check("R3 count port kept", 32'(tf_count), 32'h34);

    // R12 and R6: set irq, alternate status keeps it
    pulse_irq();
    check("R12 irq set", 32'(irq), 32'd1);
    access(1'b0, 4'd8, 32'h0, r);
    check("R6 alt keeps irq", 32'(irq), 32'd1);
    // R5 status read clears irq
    access(1'b0, 4'd7, 32'h0, r);
    check("R5 status clears irq", 32'(s_irq), 32'd0);

    // R12 set wins over a simultaneous status read
    @(negedge clk);
    req_valid = 1; req_write = 0; req_word = 4'd7; drv_irq_set = 1;
    @(negedge clk);
    req_valid = 0; drv_irq_set = 0;
    check("R12 set wins", 32'(irq), 32'd1);
    wait_rsp(r);

    // R3 command blocked while busy: no strobe, irq kept
    drv_busy = 1;
    access(1'b1, 4'd7, 32'h000000EC, r);
    drv_busy = 0;
    check("R3 cmd blocked strobe", 32'(s_cmd), 32'd0);
    check("R3 cmd blocked irq", 32'(irq), 32'd1);

    // R4 command issue
    access(1'b1, 4'd7, 32'hFFFF00A0, r);
    check("R4 cmd strobe", 32'(s_cmd), 32'd1);
    check("R4 cmd byte", 32'(s_cmd_byte), 32'hA0);
    check("R4 irq cleared", 32'(s_irq), 32'd0);
    check("R4 strobe one cycle", 32'(cmd_strobe), 32'd0);

    // R6 device control, busy does not matter
    drv_busy = 1;
    access(1'b1, 4'd8, 32'h00000104, r);
    drv_busy = 0;
    check("R6 ctl strobe", 32'(s_ctl), 32'd1);
    check("R6 ctl byte", 32'(s_ctl_byte), 32'h04);

    // R8 PIO write with drive back-pressure
    pio_wr_ready = 0;
    issue(1'b1, 4'd0, 32'h1234BEEF);
    repeat (3) @(negedge clk);
    check("R8 pio valid held", 32'(pio_wr_valid), 32'd1);
    check("R8 pio data", 32'(pio_wr_data), 32'h0000BEEF);
    check("R8 no early rsp", 32'(rsp_valid), 32'd0);
    pio_wr_ready = 1;
    wait_rsp(r);
    check("R8 pio released", 32'(pio_wr_valid), 32'd0);

    // R9 PIO read waits for drive data
    issue(1'b0, 4'd0, 32'h0);
    repeat (3) @(negedge clk);
    check("R9 waiting", {30'd0, rsp_valid, pio_rd_ready}, 32'd1);
    pio_rd_data = 16'hC0DE; pio_rd_valid = 1;
    @(negedge clk);
    pio_rd_valid = 0;
    wait_rsp(r);
    check("R9 pio read", r, 32'h0000C0DE);

    // R11 response held under host back-pressure
    rsp_ready = 0;
    issue(1'b0, 4'd9, 32'h0);
    repeat (3) @(negedge clk);
    check("R11 rsp held", {30'd0, rsp_valid, req_ready}, 32'd2);
    check("R11 rsp data", rsp_rdata, 32'hDEADBEEF);
    rsp_ready = 1;
    wait_rsp(r);
    check("R11 released", 32'(req_ready), 32'd1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule